// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block arbitrates seven interrupt requests for a small 8-bit processor core: two active-low external pins, two timer requests, a serial-port request, a general-purpose request and an analog-comparator request. Software programs a source-enable word with a master enable bit, two priority bit words that together give each source one of four levels, and a sense-mode word for the two external pins. From these settings the block presents one winning request, with its vector index and level, to the core.

The core acknowledges the request at an instruction boundary. The acknowledge marks the winning level as in service. A return strobe retires the most recent level. A new request is offered only if its level is strictly above every level now in service. Handlers therefore nest by level, and a level-3 handler is never preempted. External pins are sensed either on a falling edge, which is latched, or as a low level. An edge-latched flag clears itself when its source is acknowledged.

Top module: `irq_nest_ctl`

## Requirements
- R1: After reset, `int_req`, `in_service` and `ext_flag` are all zero, and all enables, priorities and sense modes are zero.
- R2: A source is offered only when its enable bit is set and the master bit is also set. Enable word bit i (0..6) enables vector i, and bit 7 is the master enable.
- R3: A source's level is {high-word bit i, low-word bit i}. Vector 6 (comparator) is always level 0, whatever the priority words hold.
- R4: Among pending, enabled, eligible sources, the one with the highest level is offered on `int_vec`/`int_lvl`.
- R5: At equal level the lowest vector index wins. The vector order is ext0=0, timer0=1, ext1=2, timer1=3, serial=4, general=5, comparator=6.
- R6: A request is offered only if its level is strictly greater than the highest level set in `in_service`. A level-3 handler blocks all requests.
- R7: `int_ack` while `int_req` is high sets `in_service[int_lvl]` on the next cycle. `int_ack` while `int_req` is low has no effect.
- R8: `int_ret` clears the highest set bit of `in_service`. With no bit set it has no effect.
- R9: In edge mode (sense bit = 1), a pin seen high then low on two successive clocks latches `ext_flag`. The flag stays set after the pin rises and clears when that source is acknowledged.
- R10: In level mode (sense bit = 0), `ext_flag` follows the sampled pin inverted and is not cleared by acknowledge.
- R11: Timer, serial, general and comparator requests are plain inputs. An acknowledged one that stays asserted is offered again once the in-service levels allow it.
- R12: A configuration write with `cfg_we`=1 takes effect on the next cycle. `cfg_sel` picks the word: 0 = enable, 1 = priority low, 2 = priority high, 3 = sense mode (bit 0 = ext0, bit 1 = ext1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration word select |
| cfg_wdata | input | 8 | Configuration write data |
| ext_pin_n | input | 2 | External request pins, active low |
| tmr_req | input | 2 | Timer 0/1 request flags |
| ser_req | input | 1 | Serial-port request flag |
| gp_req | input | 1 | General-purpose request flag |
| cmp_req | input | 1 | Comparator request flag |
| int_ack | input | 1 | Core accepts the offered request |
| int_ret | input | 1 | Core returns from a handler |
| int_req | output | 1 | A request is offered |
| int_vec | output | 3 | Vector index of the offered request |
| int_lvl | output | 2 | Level of the offered request |
| ext_flag | output | 2 | External pending flags, for software |
| in_service | output | 4 | In-service bit per level |

## Verification
The hardest state to reach is a two-deep nest: a level-3 handler over a level-1 handler, with the level-1 source still asserted and a lower-level request waiting. Only there does the strict-greater rule, the pop of the highest in-service bit and the re-offer of an uncleared peripheral request all matter together. The nest test builds this state with two acknowledges at different levels. It then raises a lower request, pops one level at a time and checks after each step which vector, if any, comes back.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam int NSRC    = 7;
    localparam int NLVL    = 4;
    localparam int LVL_W   = $clog2(NLVL);
    localparam int VEC_W   = $clog2(NSRC);
    localparam int CFG_W   = NSRC + 1;
    localparam int NEXT    = 2;
    localparam int CMP_IDX = NSRC - 1;
    localparam int V_EXT0  = 0;
    localparam int V_EXT1  = 2;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_PRIO_L = 2'd1,
        SEL_PRIO_H = 2'd2,
        SEL_SENSE  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic valid;
        vec_t vec;
        lvl_t lvl;
    } grant_t;

    function automatic lvl_t top_level(input logic [NLVL-1:0] bits);
        lvl_t r;
        r = '0;
        for (int l = 0; l < NLVL; l++)
            if (bits[l]) r = lvl_t'(l);
        return r;
    endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_ctl_pkg::*;
#(
    parameter int N = NSRC,
    parameter int W = CFG_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [1:0]                cfg_sel,
    input  logic [W-1:0]              cfg_wdata,
    output logic [N-1:0]              src_en,
    output logic                      glb_en,
    output logic [N-1:0][LVL_W-1:0]   src_lvl,
    output logic [NEXT-1:0]           ext_edge
);
    localparam int PW = N - 1;

    logic [W-1:0]    en_q;
    logic [PW-1:0]   plo_q, phi_q;
    logic [NEXT-1:0] sense_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            plo_q   <= '0;
            phi_q   <= '0;
            sense_q <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel_e'(cfg_sel))
                SEL_ENABLE: en_q    <= cfg_wdata;
                SEL_PRIO_L: plo_q   <= cfg_wdata[PW-1:0];
                SEL_PRIO_H: phi_q   <= cfg_wdata[PW-1:0];
                SEL_SENSE:  sense_q <= cfg_wdata[NEXT-1:0];
                default: ;
            endcase
        end
    end

    assign src_en   = en_q[N-1:0];
    assign glb_en   = en_q[W-1];
    assign ext_edge = sense_q;

    for (genvar i = 0; i < N; i++) begin : g_lvl
        if (i == N - 1) begin : g_fixed
            assign src_lvl[i] = '0;
        end else begin : g_prog
            assign src_lvl[i] = {phi_q[i], plo_q[i]};
        end
    end
endmodule

// File: rtl/irq_ext_sense.sv
module irq_ext_sense (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic ack_clr,
    output logic flag
);
    logic s1, s2, edge_q, fall;

    assign fall = s2 & ~s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= 1'b1;
            s2     <= 1'b1;
            edge_q <= 1'b0;
        end else begin
            s1 <= pin_n;
            s2 <= s1;
            if (!edge_mode)   edge_q <= 1'b0;
            else if (fall)    edge_q <= 1'b1;
            else if (ack_clr) edge_q <= 1'b0;
        end
    end

    assign flag = edge_mode ? edge_q : ~s1;

    assert_edge_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && ack_clr && !fall) |=> !edge_q);
    assert_edge_latch_R9: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && fall) |=> (edge_q || !edge_mode));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_ctl_pkg::*;
#(
    parameter int N = NSRC,
    parameter int L = NLVL
) (
    input  logic [N-1:0]            pend,
    input  logic [N-1:0]            src_en,
    input  logic                    glb_en,
    input  logic [N-1:0][LVL_W-1:0] src_lvl,
    input  logic [L-1:0]            isr,
    output grant_t                  grant
);
    logic busy;
    lvl_t floor_lvl;
    logic [N-1:0] elig;

    assign busy      = |isr;
    assign floor_lvl = top_level(isr);

    for (genvar i = 0; i < N; i++) begin : g_elig
        assign elig[i] = glb_en && src_en[i] && pend[i] &&
                         (!busy || (src_lvl[i] > floor_lvl));
    end

    always_comb begin
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i] && (!grant.valid || src_lvl[i] >= grant.lvl)) begin
                grant.valid = 1'b1;
                grant.vec   = vec_t'(i);
                grant.lvl   = src_lvl[i];
            end
        end
    end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
    import irq_ctl_pkg::*;
#(
    parameter int L = NLVL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ack,
    input  lvl_t         ack_lvl,
    input  logic         ret,
    output logic [L-1:0] isr
);
    logic [L-1:0] pop, push;

    always_comb begin
        pop = '0;
        for (int l = 0; l < L; l++)
            if (isr[l]) begin
                pop    = '0;
                pop[l] = ret;
            end
        for (int l = 0; l < L; l++)
            push[l] = ack && (ack_lvl == lvl_t'(l));
    end

    always_ff @(posedge clk) begin
        if (rst) isr <= '0;
        else     isr <= (isr & ~pop) | push;
    end

    assert_ret_pops_R8: assert property (@(posedge clk) disable iff (rst)
        (ret && !ack && |isr) |=> ($countones(isr) == $countones($past(isr)) - 1));
    assert_ret_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (ret && !ack && isr == '0) |=> (isr == '0));
endmodule

// File: rtl/irq_nest_ctl.sv
module irq_nest_ctl
    import irq_ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic [NEXT-1:0]     ext_pin_n,
    input  logic [1:0]          tmr_req,
    input  logic                ser_req,
    input  logic                gp_req,
    input  logic                cmp_req,
    input  logic                int_ack,
    input  logic                int_ret,
    output logic                int_req,
    output logic [VEC_W-1:0]    int_vec,
    output logic [LVL_W-1:0]    int_lvl,
    output logic [NEXT-1:0]     ext_flag,
    output logic [NLVL-1:0]     in_service
);
    logic [NSRC-1:0]            src_en, pend;
    logic                       glb_en;
    logic [NSRC-1:0][LVL_W-1:0] src_lvl;
    logic [NEXT-1:0]            ext_edge, ext_clr;
    grant_t                     grant;
    logic                       ack_fire;

    irq_cfg_regs u_cfg (
        .clk, .rst, .cfg_we, .cfg_sel, .cfg_wdata,
        .src_en, .glb_en, .src_lvl, .ext_edge
    );

    localparam int EXT_VEC [NEXT] = '{V_EXT0, V_EXT1};

    for (genvar e = 0; e < NEXT; e++) begin : g_ext
        assign ext_clr[e] = ack_fire && (grant.vec == vec_t'(EXT_VEC[e]));
        irq_ext_sense u_sense (
            .clk, .rst,
            .pin_n     (ext_pin_n[e]),
            .edge_mode (ext_edge[e]),
            .ack_clr   (ext_clr[e]),
            .flag      (ext_flag[e])
        );
    end

    assign pend = {cmp_req, gp_req, ser_req, tmr_req[1], ext_flag[1], tmr_req[0], ext_flag[0]};

    irq_arbiter u_arb (
        .pend, .src_en, .glb_en, .src_lvl,
        .isr   (in_service),
        .grant
    );

    assign ack_fire = int_ack && grant.valid;

    irq_inservice u_isr (
        .clk, .rst,
        .ack     (ack_fire),
        .ack_lvl (grant.lvl),
        .ret     (int_ret),
        .isr     (in_service)
    );

    assign int_req = grant.valid;
    assign int_vec = grant.vec;
    assign int_lvl = grant.lvl;

    assert_grant_enabled_R2: assert property (@(posedge clk) disable iff (rst)
        int_req |-> (glb_en && src_en[int_vec] && pend[int_vec]));
    assert_cmp_floor_R3: assert property (@(posedge clk) disable iff (rst)
        (int_req && int_vec == vec_t'(CMP_IDX)) |-> (int_lvl == '0));
    assert_preempt_strict_R6: assert property (@(posedge clk) disable iff (rst)
        (int_req && |in_service) |-> (int_lvl > top_level(in_service)));
    assert_ack_marks_R7: assert property (@(posedge clk) disable iff (rst)
        (int_ack && int_req) |=> in_service[$past(int_lvl)]);
endmodule

// File: tb/irq_nest_ctl_tb.sv
module irq_nest_ctl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] ext_pin_n = 2'b11;
    logic [1:0] tmr_req = '0;
    logic       ser_req = 1'b0, gp_req = 1'b0, cmp_req = 1'b0;
    logic       int_ack = 1'b0, int_ret = 1'b0;
    logic       int_req;
    logic [2:0] int_vec;
    logic [1:0] int_lvl;
    logic [1:0] ext_flag;
    logic [3:0] in_service;

    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    irq_nest_ctl u_dut (
        .clk, .rst, .cfg_we, .cfg_sel, .cfg_wdata, .ext_pin_n, .tmr_req,
        .ser_req, .gp_req, .cmp_req, .int_ack, .int_ret,
        .int_req, .int_vec, .int_lvl, .ext_flag, .in_service
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic ack();
        int_ack = 1'b1; tick(); int_ack = 1'b0;
    endtask

    task automatic ret();
        int_ret = 1'b1; tick(); int_ret = 1'b0;
    endtask

    task automatic clear_all();
        tmr_req = '0; ser_req = 0; gp_req = 0; cmp_req = 0; ext_pin_n = 2'b11;
        cfg(2'd0, 8'h00); cfg(2'd1, 8'h00); cfg(2'd2, 8'h00); cfg(2'd3, 8'h00);
        tick(2);
    endtask

    task automatic t_reset();
        chk("R1 req", int_req, 0);
        chk("R1 isr", in_service, 0);
        chk("R1 flag", ext_flag, 0);
        tmr_req = 2'b11; tick();
        chk("R1 enables clear", int_req, 0);
        tmr_req = '0;
    endtask

    task automatic t_enable();
        tmr_req[0] = 1;
        cfg(2'd0, 8'h02);
        chk("R2 no master", int_req, 0);
        cfg(2'd0, 8'h82);
        chk("R12 R2 req", int_req, 1);
        chk("R2 vec", int_vec, 1);
        cfg(2'd0, 8'h80);
        chk("R2 source off", int_req, 0);
        clear_all();
    endtask

    task automatic t_priority();
        tmr_req = 2'b11; ser_req = 1; cmp_req = 1;
        cfg(2'd0, 8'hFF);
        cfg(2'd1, 8'h10);
        cfg(2'd2, 8'h08);
        chk("R4 vec", int_vec, 3);
        chk("R4 lvl", int_lvl, 2);
        cfg(2'd2, 8'h00);
        chk("R4 serial lvl1 vec", int_vec, 4);
        tmr_req = '0; ser_req = 0;
        cfg(2'd1, 8'h7F); cfg(2'd2, 8'h7F);
        chk("R3 cmp vec", int_vec, 6);
        chk("R3 cmp lvl", int_lvl, 0);
        clear_all();
    endtask

    task automatic t_order();
        cfg(2'd0, 8'hFF);
        gp_req = 1; ser_req = 1; cmp_req = 1; tick();
        chk("R5 serial first", int_vec, 4);
        ser_req = 0; tick();
        chk("R5 general next", int_vec, 5);
        tmr_req = 2'b10; tick();
        chk("R5 timer1", int_vec, 3);
        clear_all();
    endtask

    task automatic t_nest();
        cfg(2'd0, 8'hFF);
        cfg(2'd1, 8'h0A);
        cfg(2'd2, 8'h08);
        tmr_req[0] = 1; tick();
        chk("R6 idle vec", int_vec, 1);
        chk("R6 idle lvl", int_lvl, 1);
        ack();
        chk("R7 isr lvl1", in_service, 4'b0010);
        chk("R6 same level blocked", int_req, 0);
        tmr_req[1] = 1; tick();
        chk("R6 nest vec", int_vec, 3);
        ack();
        chk("R7 isr 3+1", in_service, 4'b1010);
        ser_req = 1; tick();
        chk("R6 top blocks", int_req, 0);
        ret();
        chk("R8 pop top", in_service, 4'b0010);
        chk("R11 timer1 again", int_vec, 3);
        tmr_req[1] = 0; tick();
        chk("R6 equal lvl waits", int_req, 0);
        ret();
        chk("R8 pop last", in_service, 4'b0000);
        chk("R11 timer0 again", int_vec, 1);
        tmr_req = '0; ser_req = 0; tick();
        ret();
        chk("R8 empty ret", in_service, 0);
        ack();
        chk("R7 ack w/o req", in_service, 0);
        clear_all();
    endtask

    task automatic t_edge();
        cfg(2'd3, 8'h01);
        cfg(2'd0, 8'h81);
        ext_pin_n[0] = 0; tick(3);
        chk("R9 latched", ext_flag[0], 1);
        chk("R9 vec", int_vec, 0);
        ext_pin_n[0] = 1; tick(3);
        chk("R9 held", ext_flag[0], 1);
        ack();
        chk("R9 cleared", ext_flag[0], 0);
        chk("R9 isr", in_service, 4'b0001);
        ret();
        clear_all();
    endtask

    task automatic t_level();
        cfg(2'd0, 8'h85);
        ext_pin_n[1] = 0; tick(2);
        chk("R10 flag follows", ext_flag[1], 1);
        chk("R10 vec", int_vec, 2);
        ack();
        chk("R10 not cleared", ext_flag[1], 1);
        ret();
        ext_pin_n[1] = 1; tick(2);
        chk("R10 released", ext_flag[1], 0);
        chk("R10 no req", int_req, 0);
        clear_all();
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        t_reset();
        t_enable();
        t_priority();
        t_order();
        t_nest();
        t_edge();
        t_level();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule